// File: doc/BRIEF.md
# Chip-Select Strobe Sequencer

This block drives one chip-select region of an external parallel bus that reaches a compact-flash card in programmed-I/O mode. A host offers one access at a time on a valid/ready port, with an address, write data and a direction flag. The block latches the request and walks through five timed phases. First the address is set up with the chip enable inactive. Then comes the enable-to-strobe delay, then the read or write strobe pulse, then a hold with the chip enable still active, and last a closing pause. Read data is captured from the bus and returned with a one-cycle response pulse.

Every phase length comes from a configuration field, scaled by a common multiplier chosen through a 2-bit code. A wait mode lets the card lengthen the strobe through its IORDY line. After IORDY, a programmable number of extra ticks keeps the strobe and the write data on the bus. The chip-select strobes are active low.

Top module: `pbus_cs_sequencer`

## Requirements
- R1: The multiplier code selects the tick scale as follows: code 0 gives 4 cycles per tick, code 1 gives 1, code 2 gives 2 and code 3 gives 8.
- R2: A phase whose field holds N lasts exactly (N+1) times the multiplier clock cycles, so a field of 0 still lasts one tick.
- R3: An accepted access passes through its phases in a fixed order. The address phase comes first, with `bus_ce_n` high and no strobe. The delay phase follows with `bus_ce_n` low, then the strobe, then the hold with `bus_ce_n` low, and then the pause with `bus_ce_n` high. A strobe is never active while `bus_ce_n` is high.
- R4: A read pulses only `bus_oe_n`, for the read strobe field, and then holds for the read-hold field. A write pulses only `bus_we_n`, for the write strobe field, and then holds for the write-hold field.
- R5: `req_ready` falls in the cycle after a request is accepted. It stays low through the whole access and rises in the cycle right after the pause phase ends.
- R6: While `cfg_enable` is 0, `req_ready` stays 0, no request is accepted and `bus_ce_n` stays 1.
- R7: With `cfg_waitm` set, the strobe stays active past its programmed width until IORDY is seen high through a two-flop synchroniser. It then stays active for a further (`cfg_wait`+1) times the multiplier cycles. An IORDY rise after the programmed width therefore ends the base strobe two cycles after the first cycle in which the pin is high.
- R8: For a read, `bus_din` is captured on the clock edge where `bus_oe_n` returns high. `rsp_valid` pulses for exactly one cycle, in the first hold cycle, with the captured word on `rsp_rdata`.
- R9: During a write, `bus_dout_en` is 1 and `bus_dout` equals the request data in every cycle with `bus_ce_n` low. During a read, `bus_dout_en` stays 0.
- R10: `bus_addr` carries the latched request address unchanged from the address phase through the end of the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Sequencer idle and region enabled |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DW | Captured read data |
| cfg_enable | input | 1 | Region enable |
| cfg_mult | input | 2 | Multiplier code (see R1) |
| cfg_adr | input | FW | Address setup count |
| cfg_ce | input | FW | Enable-to-strobe delay count |
| cfg_oe | input | FW | Read strobe width count |
| cfg_we | input | FW | Write strobe width count |
| cfg_rdhld | input | FW | Read hold count |
| cfg_wrhld | input | FW | Write hold count |
| cfg_pause | input | FW | Closing pause count |
| cfg_waitm | input | 1 | IORDY wait mode enable |
| cfg_wait | input | FW | Extra strobe ticks after IORDY |
| bus_iordy | input | 1 | Card ready line, asynchronous |
| bus_addr | output | AW | Bus address |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_dout | output | DW | Write data onto the bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DW | Read data from the bus |

## Verification
Every bus output is decoded from registered state. Each phase therefore starts on the first clock after the request is accepted and lasts (N+1) times the multiplier cycles. The bench samples the bus once per cycle at the falling edge and measures the length of each phase, with no fixed delays. It compares each length with the value computed from the configuration. The IORDY path is checked by raising the pin after a known strobe sample, which must show a two-cycle synchroniser lag. Read capture is tested by changing `bus_din` in every strobe cycle, so only the value of the last strobe cycle is correct. The response pulse must appear in the first hold sample.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR,
        ST_CE,
        ST_STB,
        ST_EXT,
        ST_HOLD,
        ST_PAUSE
    } phase_e;
endpackage

// File: rtl/pbus_mult_decode.sv
module pbus_mult_decode (
    input  logic [1:0] code,
    output logic [1:0] shift
);
    // Non-monotonic code: 0 -> x4, 1 -> x1, 2 -> x2, 3 -> x8
    always_comb begin
        case (code)
            2'd0:    shift = 2'd2;
            2'd1:    shift = 2'd0;
            2'd2:    shift = 2'd1;
            default: shift = 2'd3;
        endcase
    end
endmodule

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pbus_cs_sequencer.sv
module pbus_cs_sequencer #(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          cfg_enable,
    input  logic [1:0]    cfg_mult,
    input  logic [FW-1:0] cfg_adr,
    input  logic [FW-1:0] cfg_ce,
    input  logic [FW-1:0] cfg_oe,
    input  logic [FW-1:0] cfg_we,
    input  logic [FW-1:0] cfg_rdhld,
    input  logic [FW-1:0] cfg_wrhld,
    input  logic [FW-1:0] cfg_pause,
    input  logic          cfg_waitm,
    input  logic [FW-1:0] cfg_wait,
    input  logic          bus_iordy,
    output logic [AW-1:0] bus_addr,
    output logic          bus_ce_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] bus_din
);
    import pbus_pkg::*;

    localparam int MAXSH = 3;
    localparam int CW    = FW + MAXSH;

    typedef struct packed {
        phase_e        state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          write;
        logic [DW-1:0] rdata;
        logic          rsp;
    } seq_t;

    seq_t       cur_q, nxt_d;
    logic [1:0] shift;
    logic       iordy_s;
    logic       leave_strobe;

    pbus_mult_decode u_mult (
        .code  (cfg_mult),
        .shift (shift)
    );

    pbus_sync #(.STAGES(2)) u_iordy (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_iordy),
        .q     (iordy_s)
    );

    // Cycles minus one for a phase field: (f+1) << shift, less one
    function automatic logic [CW-1:0] span(input logic [FW-1:0] f, input logic [1:0] sh);
        logic [CW-1:0] ext;
        ext  = {{MAXSH{1'b0}}, f} + CW'(1);
        span = (ext << sh) - CW'(1);
    endfunction

    assign req_ready = (cur_q.state == ST_IDLE) && cfg_enable;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.rsp    = 1'b0;
        leave_strobe = 1'b0;
        case (cur_q.state)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    nxt_d.state = ST_ADR;
                    nxt_d.cnt   = span(cfg_adr, shift);
                    nxt_d.addr  = req_addr;
                    nxt_d.wdata = req_wdata;
                    nxt_d.write = req_write;
                end
            end
            ST_ADR: begin
                if (cur_q.cnt != '0) nxt_d.cnt = cur_q.cnt - CW'(1);
                else begin
                    nxt_d.state = ST_CE;
                    nxt_d.cnt   = span(cfg_ce, shift);
                end
            end
            ST_CE: begin
                if (cur_q.cnt != '0) nxt_d.cnt = cur_q.cnt - CW'(1);
                else begin
                    nxt_d.state = ST_STB;
                    nxt_d.cnt   = span(cur_q.write ? cfg_we : cfg_oe, shift);
                end
            end
            ST_STB: begin
                if (cur_q.cnt != '0) nxt_d.cnt = cur_q.cnt - CW'(1);
                else if (!cfg_waitm) leave_strobe = 1'b1;
                else if (iordy_s) begin
                    nxt_d.state = ST_EXT;
                    nxt_d.cnt   = span(cfg_wait, shift);
                end
            end
            ST_EXT: begin
                if (cur_q.cnt != '0) nxt_d.cnt = cur_q.cnt - CW'(1);
                else leave_strobe = 1'b1;
            end
            ST_HOLD: begin
                if (cur_q.cnt != '0) nxt_d.cnt = cur_q.cnt - CW'(1);
                else begin
                    nxt_d.state = ST_PAUSE;
                    nxt_d.cnt   = span(cfg_pause, shift);
                end
            end
            ST_PAUSE: begin
                if (cur_q.cnt != '0) nxt_d.cnt = cur_q.cnt - CW'(1);
                else nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
        if (leave_strobe) begin
            nxt_d.state = ST_HOLD;
            nxt_d.cnt   = span(cur_q.write ? cfg_wrhld : cfg_rdhld, shift);
            if (!cur_q.write) begin
                nxt_d.rdata = bus_din;
                nxt_d.rsp   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    logic ce_active, strobe_active;
    assign ce_active     = (cur_q.state == ST_CE) || (cur_q.state == ST_STB) ||
                           (cur_q.state == ST_EXT) || (cur_q.state == ST_HOLD);
    assign strobe_active = (cur_q.state == ST_STB) || (cur_q.state == ST_EXT);

    assign bus_addr    = cur_q.addr;
    assign bus_ce_n    = !ce_active;
    assign bus_oe_n    = !(strobe_active && !cur_q.write);
    assign bus_we_n    = !(strobe_active && cur_q.write);
    assign bus_dout    = cur_q.wdata;
    assign bus_dout_en = ce_active && cur_q.write;
    assign rsp_valid   = cur_q.rsp;
    assign rsp_rdata   = cur_q.rdata;

    // R3: a strobe only inside the chip-enable window
    p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);

    // R5: acceptance drops ready and opens the address phase with CE high
    p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && bus_ce_n));

    // R6: a disabled idle region stays idle
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && cur_q.state == ST_IDLE) |=> (cur_q.state == ST_IDLE && bus_ce_n));

    // R7: strobe held while waiting on synchronised IORDY
    p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_STB && cur_q.cnt == '0 && cfg_waitm && !iordy_s)
        |=> (!bus_oe_n || !bus_we_n));

    // R8: response pulse right after the read strobe ends
    p_rsp_at_oe_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (bus_oe_n && $past(!bus_oe_n)));

    // R10: address stable across an access
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state != ST_IDLE && $past(cur_q.state) != ST_IDLE) |-> $stable(bus_addr));
endmodule

// File: tb/tb_pbus_cs_sequencer.sv
module tb_pbus_cs_sequencer;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int FW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic cfg_enable = 1'b1;
    logic [1:0] cfg_mult = 2'd1;
    logic [FW-1:0] cfg_adr = '0, cfg_ce = '0, cfg_oe = '0, cfg_we = '0;
    logic [FW-1:0] cfg_rdhld = '0, cfg_wrhld = '0, cfg_pause = '0, cfg_wait = '0;
    logic cfg_waitm = 1'b0;
    logic bus_iordy = 1'b1;
    logic [AW-1:0] bus_addr;
    logic bus_ce_n, bus_oe_n, bus_we_n, bus_dout_en;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din = '0;

    int errors = 0;
    int checks = 0;

    always #5ns clk = ~clk;

    pbus_cs_sequencer #(.AW(AW), .DW(DW), .FW(FW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cfg_enable(cfg_enable), .cfg_mult(cfg_mult),
        .cfg_adr(cfg_adr), .cfg_ce(cfg_ce), .cfg_oe(cfg_oe), .cfg_we(cfg_we),
        .cfg_rdhld(cfg_rdhld), .cfg_wrhld(cfg_wrhld), .cfg_pause(cfg_pause),
        .cfg_waitm(cfg_waitm), .cfg_wait(cfg_wait),
        .bus_iordy(bus_iordy), .bus_addr(bus_addr),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mult_of(input logic [1:0] code);
        case (code)
            2'd0:    return 4;
            2'd1:    return 1;
            2'd2:    return 2;
            default: return 8;
        endcase
    endfunction

    // One access; late >= 0 raises IORDY after that many strobe samples
    task automatic access(input logic wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input int late);
        int m, ea, ec, es, eh, ep;
        int sa, sc, ss, sh, sp, seg, n, rsp_n;
        bit rsp_pos, bad_order, bad_wrong, bad_data, bad_addr, strobe;
        m  = mult_of(cfg_mult);
        ea = (int'(cfg_adr) + 1) * m;
        ec = (int'(cfg_ce) + 1) * m;
        es = (int'(wr ? cfg_we : cfg_oe) + 1) * m;
        eh = (int'(wr ? cfg_wrhld : cfg_rdhld) + 1) * m;
        ep = (int'(cfg_pause) + 1) * m;
        if (cfg_waitm) es = ((late >= 0) ? late + 2 : es) + (int'(cfg_wait) + 1) * m;
        sa = 0; sc = 0; ss = 0; sh = 0; sp = 0; seg = 0; n = 0; rsp_n = 0;
        rsp_pos = 0; bad_order = 0; bad_wrong = 0; bad_data = 0; bad_addr = 0;
        if (late >= 0) begin
            bus_iordy = 1'b0;
            repeat (3) @(negedge clk);
        end
        req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && n < 5000) begin
            n++;
            strobe = !bus_oe_n || !bus_we_n;
            if (seg == 0 && !bus_ce_n) seg = 1;
            if (seg == 1 && strobe) seg = 2;
            else if (seg == 2 && !strobe) seg = 3;
            else if (seg == 3 && bus_ce_n) seg = 4;
            if ((seg == 4 && !bus_ce_n) || (seg != 2 && strobe)) bad_order = 1;
            case (seg)
                0: sa++;
                1: sc++;
                2: ss++;
                3: sh++;
                default: sp++;
            endcase
            if (wr ? !bus_oe_n : !bus_we_n) bad_wrong = 1;
            if (bus_addr != a) bad_addr = 1;
            if (!bus_ce_n && (wr ? (!bus_dout_en || bus_dout != wd) : bus_dout_en)) bad_data = 1;
            if (bus_ce_n && bus_dout_en) bad_data = 1;
            if (rsp_valid) begin
                rsp_n++;
                rsp_pos = (seg == 3 && sh == 1);
            end
            if (seg == 2) begin
                if (late >= 0 && ss == late) bus_iordy = 1'b1;
                bus_din = DW'(16'hA000 + ss);
            end else if (seg == 3) begin
                bus_din = 16'h5555;
            end
            @(negedge clk);
        end
        check(n < 5000, "R5 access completes", n, 0);
        check(sa == ea, "R2 address phase", sa, ea);
        check(sc == ec, "R2 delay phase", sc, ec);
        check(ss == es, cfg_waitm ? "R7 strobe with wait" : "R1 strobe width", ss, es);
        check(sh == eh, "R4 hold phase", sh, eh);
        check(sp == ep, "R5 pause then ready", sp, ep);
        check(seg == 4 && !bad_order, "R3 phase order", seg, 4);
        check(!bad_wrong, "R4 strobe type", bad_wrong, 0);
        check(!bad_data, "R9 data drive", bad_data, 0);
        check(!bad_addr, "R10 address", bad_addr, 0);
        if (!wr) begin
            check(rsp_rdata == DW'(16'hA000 + es), "R8 read capture", rsp_rdata, 16'hA000 + es);
            check(rsp_n == 1 && rsp_pos, "R8 response pulse", rsp_n, 1);
        end
        bus_iordy = 1'b1;
        bus_din = '0;
    endtask

    task automatic set_fields(input int which);
        if (which == 0) begin
            cfg_adr = 4'd0; cfg_ce = 4'd1; cfg_oe = 4'd2; cfg_we = 4'd3;
            cfg_rdhld = 4'd1; cfg_wrhld = 4'd0; cfg_pause = 4'd2; cfg_wait = 4'd1;
        end else begin
            cfg_adr = 4'd3; cfg_ce = 4'd0; cfg_oe = 4'd5; cfg_we = 4'd1;
            cfg_rdhld = 4'd0; cfg_wrhld = 4'd2; cfg_pause = 4'd0; cfg_wait = 4'd2;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        bit ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_ce_n && bus_oe_n && bus_we_n && !bus_dout_en, "R3 reset strobes idle", bus_ce_n, 1);
        check(req_ready && !rsp_valid, "R5 reset ready", req_ready, 1);

        // R1/R2 sweep: every multiplier code, two field sets, both directions
        for (int code = 0; code < 4; code++) begin
            for (int fs = 0; fs < 2; fs++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    cfg_mult = 2'(code);
                    set_fields(fs);
                    access(wr[0], AW'(8'h10 + code * 4 + fs * 2 + wr), DW'(16'h1234 + code * 16 + fs), -1);
                end
            end
        end

        // R7: wait mode, IORDY late and IORDY already high
        cfg_waitm = 1'b1;
        cfg_mult = 2'd1; set_fields(0);
        access(1'b0, 8'h41, 16'h0, 6);
        access(1'b1, 8'h42, 16'hBEEF, 7);
        access(1'b0, 8'h43, 16'h0, -1);
        cfg_mult = 2'd2; set_fields(1);
        access(1'b0, 8'h44, 16'h0, 15);
        cfg_waitm = 1'b0;

        // R6: disabled region ignores requests
        cfg_enable = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h77;
        ok = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (req_ready || !bus_ce_n || !bus_oe_n) ok = 0;
        end
        check(ok, "R6 disabled region quiet", ok, 1);
        req_valid = 1'b0;
        cfg_enable = 1'b1;
        @(negedge clk);
        check(req_ready && bus_ce_n, "R6 idle after re-enable", req_ready, 1);
        cfg_mult = 2'd1; set_fields(0);
        access(1'b0, 8'h78, 16'h0, -1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule